// File: doc/BRIEF.md
# Four-Tier Interrupt Mask and Request Aggregator

This block gathers device interrupt requests into four separate priority tiers, named 3, 4, 5 and 6. Each tier takes up to four level-sensitive request lines. It keeps an enable mask for each tier and drives one request output per tier. Software reaches the block over a small byte-wide register bus. At a tier's status address it reads the live, synchronised request pattern. At the tier's enable address it reads the current mask.

The enable mask is never overwritten as a whole. A write carries a mask of devices in its low nibble and a command in its top bit. With the top bit at 1, the marked devices are enabled. With the top bit at 0, the marked devices are disabled. Unmarked devices keep their state. Independent drivers can therefore switch their own devices on and off without a read-modify-write race.

Top module: `irq_tier_ctrl`

## Requirements
- R1: Tier index i (0..3, meaning tiers 3..6) has its status register at offset 0x130 + 0x10*i and its enable register at 0x134 + 0x10*i. Tier i takes request lines devReq[4*i+3 : 4*i] and drives levelIrq[i].
- R2: A status read returns the synchronised request lines of that tier in bits 3:0, with bit n for device n, whatever the enable mask holds. Bits 7:4 read 0.
- R3: A change on a request line shows in status two rising clock edges after it is applied, and not after the first edge.
- R4: A write to an enable register with bit 7 = 1 sets every enable bit whose bit in data 3:0 is 1. Other enable bits keep their value.
- R5: A write to an enable register with bit 7 = 0 clears every enable bit whose bit in data 3:0 is 1. Other enable bits keep their value.
- R6: Writes to status registers and to unmapped offsets change no enable bit. Data bits 6:4 of an enable write have no effect.
- R7: levelIrq[i] is 1 exactly when status and enable of tier i share a set bit. It follows an enable write at the same clock edge that updates the enable register.
- R8: After reset every enable bit, every status bit and every levelIrq output is 0.
- R9: A read of any unmapped offset returns 0x00. An enable readback has bits 7:4 at 0.
- R10: A write to one tier's enable register leaves the other tiers' enable registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 12 | Byte offset of the access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational from busAddr |
| devReq | input | 16 | Raw device request lines, four per tier |
| levelIrq | output | 4 | Per-tier request output |

## Verification
The assertions assume that busWrEn is a clean single-cycle pulse with busAddr and busWrData stable around the sampling edge. They also assume that devReq is treated as asynchronous, so only its value at a clock edge counts. The bench changes every bus and request input on the falling edge and keeps devReq at zero during reset. The latency property is armed only after two edges out of reset, so pre-reset request values never reach it.

// File: rtl/irq_tier_pkg.sv
package irq_tier_pkg;
  localparam int LVL_COUNT = 4;
  localparam int SRC_COUNT = 4;
  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 8;
  localparam int LVL_IDX_W = $clog2(LVL_COUNT);
  localparam int SET_BIT   = DATA_W - 1;
  localparam int REQ_W     = LVL_COUNT * SRC_COUNT;

  localparam logic [ADDR_W-1:0] BASE_OFF   = 12'h130;
  localparam logic [ADDR_W-1:0] LVL_STRIDE = 12'h010;
  localparam logic [ADDR_W-1:0] ENA_DELTA  = 12'h004;

  typedef enum logic [1:0] {RD_NONE, RD_STAT, RD_ENA} rdKind_e;

  typedef struct packed {
    logic [LVL_COUNT-1:0] enaWr;
    rdKind_e              rdKind;
    logic [LVL_IDX_W-1:0] rdLvl;
  } busStrb_t;
endpackage

// File: rtl/irq_tier_decode.sv
module irq_tier_decode
  import irq_tier_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output busStrb_t          strb
);
  always_comb begin
    strb = '{enaWr: '0, rdKind: RD_NONE, rdLvl: '0};
    for (int i = 0; i < LVL_COUNT; i++) begin
      if (busAddr == ADDR_W'(BASE_OFF + LVL_STRIDE * ADDR_W'(i))) begin
        strb.rdKind = RD_STAT;
        strb.rdLvl  = LVL_IDX_W'(i);
      end
      if (busAddr == ADDR_W'(BASE_OFF + LVL_STRIDE * ADDR_W'(i) + ENA_DELTA)) begin
        strb.rdKind   = RD_ENA;
        strb.rdLvl    = LVL_IDX_W'(i);
        strb.enaWr[i] = busWrEn;
      end
    end
  end

  // R10: a write reaches at most one tier
  p_one_tier_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.enaWr));

  // R6: no enable write without a bus write
  p_wr_needs_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |-> (strb.enaWr == '0));
endmodule

// File: rtl/irq_tier_path.sv
module irq_tier_path
  import irq_tier_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  busStrb_t          strb,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [REQ_W-1:0]  devReq,
  output logic [DATA_W-1:0] busRdData,
  output logic [LVL_COUNT-1:0] levelIrq
);
  logic [SRC_COUNT-1:0] syncA [LVL_COUNT];
  logic [SRC_COUNT-1:0] syncB [LVL_COUNT];
  logic [SRC_COUNT-1:0] enaQ  [LVL_COUNT];
  logic [1:0]           upCnt;

  wire [SRC_COUNT-1:0] wrMask = busWrData[SRC_COUNT-1:0];
  wire                 wrSet  = busWrData[SET_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            upCnt <= '0;
    else if (upCnt != 2'd2) upCnt <= upCnt + 2'd1;
  end

  for (genvar gl = 0; gl < LVL_COUNT; gl++) begin : g_lvl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA[gl] <= '0;
        syncB[gl] <= '0;
        enaQ[gl]  <= '0;
      end else begin
        syncA[gl] <= devReq[gl*SRC_COUNT +: SRC_COUNT];
        syncB[gl] <= syncA[gl];
        if (strb.enaWr[gl])
          enaQ[gl] <= wrSet ? (enaQ[gl] | wrMask) : (enaQ[gl] & ~wrMask);
      end
    end

    assign levelIrq[gl] = |(syncB[gl] & enaQ[gl]);

    p_ena_set_r4: assert property (@(posedge clk) disable iff (!rstN)
      (strb.enaWr[gl] && wrSet) |=> enaQ[gl] == ($past(enaQ[gl]) | $past(wrMask)));

    p_ena_clr_r5: assert property (@(posedge clk) disable iff (!rstN)
      (strb.enaWr[gl] && !wrSet) |=> enaQ[gl] == ($past(enaQ[gl]) & ~$past(wrMask)));

    p_ena_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
      !strb.enaWr[gl] |=> $stable(enaQ[gl]));

    p_sync_lat_r3: assert property (@(posedge clk) disable iff (!rstN)
      (upCnt == 2'd2) |-> syncB[gl] == $past(devReq[gl*SRC_COUNT +: SRC_COUNT], 2));

    p_irq_needs_ena_r7: assert property (@(posedge clk) disable iff (!rstN)
      (enaQ[gl] == '0) |-> !levelIrq[gl]);
  end

  always_comb begin
    busRdData = '0;
    unique case (strb.rdKind)
      RD_STAT: busRdData[SRC_COUNT-1:0] = syncB[strb.rdLvl];
      RD_ENA:  busRdData[SRC_COUNT-1:0] = enaQ[strb.rdLvl];
      default: busRdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_tier_ctrl.sv
module irq_tier_ctrl
  import irq_tier_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [DATA_W-1:0]    busWrData,
  output logic [DATA_W-1:0]    busRdData,
  input  logic [REQ_W-1:0]     devReq,
  output logic [LVL_COUNT-1:0] levelIrq
);
  busStrb_t strb;

  irq_tier_decode u_decode (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strb    (strb)
  );

  irq_tier_path u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busWrData (busWrData),
    .devReq    (devReq),
    .busRdData (busRdData),
    .levelIrq  (levelIrq)
  );

  // R9: upper readback nibble is always zero
  p_rd_upper_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    busRdData[DATA_W-1:SRC_COUNT] == '0);
endmodule

// File: tb/irq_tier_ctrl_bench.sv
`timescale 1ns/1ps
module irq_tier_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic [15:0] devReq = '0;
  logic [3:0]  levelIrq;

  int checks = 0;
  int fails = 0;
  logic [3:0] mEna [4];
  logic [3:0] mReq [4];

  always #5 clk = ~clk;

  irq_tier_ctrl u_irq_tier_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .devReq(devReq),
    .levelIrq(levelIrq)
  );

  function automatic logic [11:0] statAddr(int l); return 12'h130 + 12'(l*16); endfunction
  function automatic logic [11:0] enaAddr(int l);  return 12'h134 + 12'(l*16); endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(logic [11:0] a, logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdReg(logic [11:0] a, output logic [7:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic checkEnables(string req);
    logic [7:0] d;
    for (int l = 0; l < 4; l++) begin
      rdReg(enaAddr(l), d);
      check(req, d, {4'h0, mEna[l]});
    end
  endtask

  task automatic applyReq();
    for (int l = 0; l < 4; l++) devReq[l*4 +: 4] = mReq[l];
  endtask

  function automatic logic [3:0] expIrq();
    logic [3:0] r;
    for (int l = 0; l < 4; l++) r[l] = |(mReq[l] & mEna[l]);
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    for (int l = 0; l < 4; l++) begin mEna[l] = '0; mReq[l] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R8: reset state
    check("R8 irq", levelIrq, 0);
    for (int l = 0; l < 4; l++) begin
      rdReg(statAddr(l), d); check("R8 status", d, 0);
      rdReg(enaAddr(l), d);  check("R8 enable", d, 0);
    end

    // R1 R4 R5 R10 R6(bits 6:4): sweep every data byte on every tier
    for (int l = 0; l < 4; l++) begin
      for (int v = 0; v < 256; v++) begin
        wrReg(enaAddr(l), 8'(v));
        if (v[7]) mEna[l] = mEna[l] | 4'(v);
        else      mEna[l] = mEna[l] & ~4'(v);
        checkEnables(v[7] ? "R4 R10 set" : "R5 R10 clear");
      end
    end
    check("R7 no request", levelIrq, 0);

    // R3: two-edge latency on tier 0
    mReq[0] = 4'hA; applyReq();
    @(posedge clk); @(negedge clk);
    rdReg(statAddr(0), d); check("R3 after one edge", d, 0);
    @(posedge clk); @(negedge clk);
    rdReg(statAddr(0), d); check("R3 after two edges", d, 8'h0A);

    // R2 R7: enable and request pattern sweep
    for (int e = 0; e < 16; e++) begin
      for (int l = 0; l < 4; l++) begin
        wrReg(enaAddr(l), 8'h0F);
        wrReg(enaAddr(l), 8'h80 | 8'((e + l*3) & 15));
        mEna[l] = 4'((e + l*3) & 15);
      end
      check("R7 after enable write", levelIrq, expIrq());
      for (int p = 0; p < 16; p++) begin
        for (int l = 0; l < 4; l++) mReq[l] = 4'((p + l*5) & 15);
        applyReq();
        @(posedge clk); @(posedge clk); @(negedge clk);
        for (int l = 0; l < 4; l++) begin
          rdReg(statAddr(l), d); check("R2 status", d, {4'h0, mReq[l]});
        end
        check("R7 irq", levelIrq, expIrq());
      end
    end

    // R7: output follows an enable write at the same edge
    for (int l = 0; l < 4; l++) mReq[l] = 4'h1;
    applyReq();
    wrReg(enaAddr(2), 8'h0F); mEna[2] = 4'h0;
    wrReg(enaAddr(2), 8'h81); mEna[2] = 4'h1;
    check("R7 enable edge", levelIrq, expIrq());
    wrReg(enaAddr(2), 8'h01); mEna[2] = 4'h0;
    check("R7 disable edge", levelIrq, expIrq());

    // R6: writes to status and unmapped offsets
    for (int l = 0; l < 4; l++) begin
      wrReg(statAddr(l), 8'h8F);
      wrReg(statAddr(l), 8'h0F);
    end
    wrReg(12'h138, 8'h8F); wrReg(12'h170, 8'h0F); wrReg(12'h000, 8'h8F);
    wrReg(12'h135, 8'h0F); wrReg(12'h124, 8'h8F);
    checkEnables("R6 ignored writes");

    // R9: unmapped reads
    rdReg(12'h000, d); check("R9 unmapped", d, 0);
    rdReg(12'h12C, d); check("R9 unmapped", d, 0);
    rdReg(12'h138, d); check("R9 unmapped", d, 0);
    rdReg(12'h131, d); check("R9 unmapped", d, 0);
    rdReg(12'h170, d); check("R9 unmapped", d, 0);
    rdReg(12'h174, d); check("R9 unmapped", d, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule